// File: doc/BRIEF.md
# Windowed Register File

The block is the integer register file of a processor whose registers are organised as overlapping windows. Each access sees 32 architectural registers. Eight are globals shared by all windows. The other 24 come from the window that a current window pointer selects: eight locals that belong to that window alone, eight ins, and eight outs. A save strobe moves the pointer down by one window and a restore strobe moves it up by one, in both cases modulo the window count. The outs of a window and the ins of the window below it are the same physical registers, so a caller can pass arguments without copying them.

An invalid-window mask holds one bit per window. A save or restore whose target window is marked in the mask is refused. The pointer stays where it is and a one-cycle overflow or underflow trap is raised, so that trap software can spill or fill the window. Architectural 5-bit addresses are translated to physical entries through the pointer. The physical array holds 8 + 16 × window-count words and has two registered read ports and one write port, so it maps onto block RAM.

Top module: `winreg_top`

## Requirements
- R1: After a synchronous reset, `cwp` is 0, both trap outputs are low and every mask bit is clear.
- R2: Addresses 1–7 select global registers that hold the same value in every window.
- R3: Address 0 always reads as zero, and a write to address 0 changes nothing.
- R4: A save alone sets `cwp` to `cwp-1`, with 0 wrapping to NWIN-1. A restore alone sets it to `cwp+1`, with NWIN-1 wrapping to 0. The new value appears one cycle after the strobe.
- R5: Addresses 8–15 (outs) of window w and addresses 24–31 (ins) of window w-1 mod NWIN are the same storage, entry by entry in address order.
- R6: Addresses 16–23 (locals) of a window are separate from the locals of every other window.
- R7: A save whose target window has its mask bit set leaves `cwp` unchanged and drives `trap_ovf` high for exactly the following cycle.
- R8: A restore whose target window has its mask bit set leaves `cwp` unchanged and drives `trap_unf` high for exactly the following cycle.
- R9: Save and restore asserted in the same cycle are ignored: `cwp` does not move and no trap is raised.
- R10: Read data appears one cycle after the address. A read of a register written in the same cycle returns the value it held before the write.
- R11: A write issued in the same cycle as a save or restore goes to the window selected before the pointer moves.
- R12: Bit i of `mask_wdata` marks window i. A mask write takes effect from the next cycle, so a save or restore in the same cycle is checked against the old mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Architectural address, read port A |
| rd_data_a | output | DW | Registered read data, port A |
| rd_addr_b | input | 5 | Architectural address, read port B |
| rd_data_b | output | DW | Registered read data, port B |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Architectural write address |
| wr_data | input | DW | Write data |
| save | input | 1 | Move to the next lower window |
| restore | input | 1 | Move back to the next higher window |
| mask_we | input | 1 | Load the invalid-window mask |
| mask_wdata | input | NWIN | New mask value, one bit per window |
| cwp | output | 5 | Current window pointer |
| trap_ovf | output | 1 | One-cycle pulse for a refused save |
| trap_unf | output | 1 | One-cycle pulse for a refused restore |

## Verification
The bench builds the block with NWIN = 4 and DW = 32. With only four windows, random save and restore streams wrap the pointer through both ends many times. A sparse random mask then refuses moves into marked windows often enough to exercise both trap kinds. The small window count also makes the in/out aliasing between neighbours recur within a few strobes, so data written in one window is read back through the neighbouring window's names after short random detours. Directed steps pin down the same-cycle cases: read during write, write during a pointer move, mask load during a move, and both strobes together.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  // register group selected by arch address bits [4:3]
  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } reg_grp_e;

  localparam int unsigned N_GLOBAL = 8;
  localparam int unsigned WIN_SPAN = 16;
  localparam int unsigned CWP_W    = 5;

  function automatic logic [CWP_W-1:0] win_dec(input logic [CWP_W-1:0] w, input int unsigned n);
    return (w == '0) ? CWP_W'(n - 1) : CWP_W'(w - 1'b1);
  endfunction

  function automatic logic [CWP_W-1:0] win_inc(input logic [CWP_W-1:0] w, input int unsigned n);
    return (w == CWP_W'(n - 1)) ? '0 : CWP_W'(w + 1'b1);
  endfunction
endpackage

// File: rtl/winreg_xlate.sv
module winreg_xlate
  import winreg_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned PAW  = 8
) (
  input  logic [4:0]       arch,
  input  logic [CWP_W-1:0] win,
  output logic [PAW-1:0]   phys
);
  reg_grp_e    grp;
  int unsigned base;

  always_comb begin
    grp = reg_grp_e'(arch[4:3]);
    unique case (grp)
      GRP_GLOBAL: base = 0;
      GRP_OUT:    base = N_GLOBAL + WIN_SPAN * int'(win);
      GRP_LOCAL:  base = N_GLOBAL + WIN_SPAN * int'(win) + 8;
      default:    base = N_GLOBAL + WIN_SPAN * int'(win_inc(win, NWIN));
    endcase
    phys = PAW'(base + int'(arch[2:0]));
  end
endmodule

// File: rtl/winreg_ptr.sv
module winreg_ptr
  import winreg_pkg::*;
#(
  parameter int unsigned NWIN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             save,
  input  logic             restore,
  input  logic             mask_we,
  input  logic [NWIN-1:0]  mask_wdata,
  output logic [CWP_W-1:0] cwp,
  output logic             trap_ovf,
  output logic             trap_unf
);
  localparam int unsigned IW = (NWIN > 1) ? $clog2(NWIN) : 1;

  logic [NWIN-1:0]  wim;
  logic [CWP_W-1:0] dn_w, up_w;
  logic             dn_bad, up_bad;

  always_comb begin
    dn_w   = win_dec(cwp, NWIN);
    up_w   = win_inc(cwp, NWIN);
    dn_bad = wim[dn_w[IW-1:0]];
    up_bad = wim[up_w[IW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp      <= '0;
      wim      <= '0;
      trap_ovf <= 1'b0;
      trap_unf <= 1'b0;
    end else begin
      trap_ovf <= 1'b0;
      trap_unf <= 1'b0;
      if (mask_we) wim <= mask_wdata;
      if (save && !restore) begin
        if (dn_bad) trap_ovf <= 1'b1;
        else        cwp      <= dn_w;
      end else if (restore && !save) begin
        if (up_bad) trap_unf <= 1'b1;
        else        cwp      <= up_w;
      end
    end
  end
endmodule

// File: rtl/winreg_bank.sv
module winreg_bank #(
  parameter int unsigned DEPTH = 136,
  parameter int unsigned PAW   = 8,
  parameter int unsigned DW    = 32
) (
  input  logic           clk,
  input  logic           we,
  input  logic [PAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [PAW-1:0] raddr_a,
  input  logic           zero_a,
  output logic [DW-1:0]  q_a,
  input  logic [PAW-1:0] raddr_b,
  input  logic           zero_b,
  output logic [DW-1:0]  q_b
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] qa_r, qb_r;
  logic          za_r, zb_r;

  // read-before-write: the registered read sees the pre-write word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    qa_r <= mem[raddr_a];
    qb_r <= mem[raddr_b];
    za_r <= zero_a;
    zb_r <= zero_b;
  end

  assign q_a = za_r ? '0 : qa_r;
  assign q_b = zb_r ? '0 : qb_r;
endmodule

// File: rtl/winreg_top.sv
module winreg_top
  import winreg_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [4:0]      rd_addr_a,
  output logic [DW-1:0]   rd_data_a,
  input  logic [4:0]      rd_addr_b,
  output logic [DW-1:0]   rd_data_b,
  input  logic            wr_en,
  input  logic [4:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            save,
  input  logic            restore,
  input  logic            mask_we,
  input  logic [NWIN-1:0] mask_wdata,
  output logic [4:0]      cwp,
  output logic            trap_ovf,
  output logic            trap_unf
);
  localparam int unsigned DEPTH = N_GLOBAL + WIN_SPAN * NWIN;
  localparam int unsigned PAW   = $clog2(DEPTH);
  localparam int unsigned NPORT = 3;

  logic [4:0]     arch [NPORT];
  logic [PAW-1:0] phys [NPORT];

  assign arch[0] = rd_addr_a;
  assign arch[1] = rd_addr_b;
  assign arch[2] = wr_addr;

  winreg_ptr #(.NWIN(NWIN)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .save       (save),
    .restore    (restore),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .cwp        (cwp),
    .trap_ovf   (trap_ovf),
    .trap_unf   (trap_unf)
  );

  // all ports translate through the pre-move pointer
  for (genvar p = 0; p < NPORT; p++) begin : g_xl
    winreg_xlate #(.NWIN(NWIN), .PAW(PAW)) u_xl (
      .arch (arch[p]),
      .win  (cwp),
      .phys (phys[p])
    );
  end

  winreg_bank #(.DEPTH(DEPTH), .PAW(PAW), .DW(DW)) u_bank (
    .clk     (clk),
    .we      (wr_en && (wr_addr != 5'd0)),
    .waddr   (phys[2]),
    .wdata   (wr_data),
    .raddr_a (phys[0]),
    .zero_a  (rd_addr_a == 5'd0),
    .q_a     (rd_data_a),
    .raddr_b (phys[1]),
    .zero_b  (rd_addr_b == 5'd0),
    .q_b     (rd_data_b)
  );
endmodule

// File: rtl/winreg_chk.sv
module winreg_chk #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned DW   = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [4:0]    rd_addr_a,
  input logic [DW-1:0] rd_data_a,
  input logic [4:0]    rd_addr_b,
  input logic [DW-1:0] rd_data_b,
  input logic          save,
  input logic          restore,
  input logic [4:0]    cwp,
  input logic          trap_ovf,
  input logic          trap_unf
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (cwp == 5'd0 && !trap_ovf && !trap_unf));

  p_zero_read_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == 5'd0) |=> (rd_data_a == '0));

  p_zero_read_b_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_b == 5'd0) |=> (rd_data_b == '0));

  p_save_move_r4: assert property (@(posedge clk) disable iff (rst)
    (save && !restore) |=> (trap_ovf ||
      cwp == (($past(cwp) == 5'd0) ? 5'(NWIN - 1) : $past(cwp) - 5'd1)));

  p_restore_move_r4: assert property (@(posedge clk) disable iff (rst)
    (restore && !save) |=> (trap_unf ||
      cwp == (($past(cwp) == 5'(NWIN - 1)) ? 5'd0 : $past(cwp) + 5'd1)));

  p_ovf_hold_r7: assert property (@(posedge clk) disable iff (rst)
    trap_ovf |-> (cwp == $past(cwp) && $past(save)));

  p_unf_hold_r8: assert property (@(posedge clk) disable iff (rst)
    trap_unf |-> (cwp == $past(cwp) && $past(restore)));

  p_both_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (save && restore) |=> (!trap_ovf && !trap_unf && $stable(cwp)));

  p_cwp_range_r4: assert property (@(posedge clk) disable iff (rst)
    cwp < 5'(NWIN));
endmodule

bind winreg_top winreg_chk #(.NWIN(NWIN), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_addr_a (rd_addr_a),
  .rd_data_a (rd_data_a),
  .rd_addr_b (rd_addr_b),
  .rd_data_b (rd_data_b),
  .save      (save),
  .restore   (restore),
  .cwp       (cwp),
  .trap_ovf  (trap_ovf),
  .trap_unf  (trap_unf)
);

// File: tb/sim_winreg_top.sv
`timescale 1ns/1ps
module sim_winreg_top;
  localparam int NW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [4:0]    rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [DW-1:0] rd_data_a, rd_data_b, wr_data = '0;
  logic          wr_en = 1'b0, save = 1'b0, restore = 1'b0, mask_we = 1'b0;
  logic [NW-1:0] mask_wdata = '0;
  logic [4:0]    cwp;
  logic          trap_ovf, trap_unf;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  winreg_top #(.NWIN(NW), .DW(DW)) u0 (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .save(save), .restore(restore),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .cwp(cwp), .trap_ovf(trap_ovf), .trap_unf(trap_unf)
  );

  // reference state, organised by architectural meaning
  logic [DW-1:0] m_glob [8];
  logic [DW-1:0] m_out  [NW][8];   // outs of window w; ins of w-1 (R5)
  logic [DW-1:0] m_loc  [NW][8];
  bit            v_glob [8];
  bit            v_out  [NW][8];
  bit            v_loc  [NW][8];
  logic [NW-1:0] m_wim;
  int            m_cwp;

  function automatic string rtag(input int a);
    if (a == 0)  return "R3";
    if (a < 8)   return "R2";
    if (a < 16)  return "R5";
    if (a < 24)  return "R6";
    return "R5";
  endfunction

  function automatic logic [DW-1:0] mread(input int a, output bit ok);
    int k = a % 8;
    ok = 1'b1;
    if (a == 0) return '0;
    if (a < 8)  begin ok = v_glob[k]; return m_glob[k]; end
    if (a < 16) begin ok = v_out[m_cwp][k]; return m_out[m_cwp][k]; end
    if (a < 24) begin ok = v_loc[m_cwp][k]; return m_loc[m_cwp][k]; end
    ok = v_out[(m_cwp + 1) % NW][k];
    return m_out[(m_cwp + 1) % NW][k];
  endfunction

  function automatic void mwrite(input int a, input logic [DW-1:0] d);
    int k = a % 8;
    if (a == 0) return;
    if (a < 8)       begin m_glob[k] = d; v_glob[k] = 1'b1; end
    else if (a < 16) begin m_out[m_cwp][k] = d; v_out[m_cwp][k] = 1'b1; end
    else if (a < 24) begin m_loc[m_cwp][k] = d; v_loc[m_cwp][k] = 1'b1; end
    else begin m_out[(m_cwp + 1) % NW][k] = d; v_out[(m_cwp + 1) % NW][k] = 1'b1; end
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, model the edge, compare at the next negedge
  task automatic step(input bit sv, input bit rs, input bit we, input int wa,
                      input logic [DW-1:0] wd, input int ra, input int rb,
                      input bit mwe, input logic [NW-1:0] mw, input string ttag);
    bit va, vb, e_ovf, e_unf;
    logic [DW-1:0] ea, eb;
    int tgt, ncwp;
    string ctag;
    save = sv; restore = rs; wr_en = we; wr_addr = 5'(wa); wr_data = wd;
    rd_addr_a = 5'(ra); rd_addr_b = 5'(rb); mask_we = mwe; mask_wdata = mw;
    ea = mread(ra, va);                 // R10: pre-write value
    eb = mread(rb, vb);
    e_ovf = 0; e_unf = 0; ncwp = m_cwp;
    if (sv && !rs) begin
      tgt = (m_cwp + NW - 1) % NW;
      if (m_wim[tgt]) e_ovf = 1; else ncwp = tgt;
    end else if (rs && !sv) begin
      tgt = (m_cwp + 1) % NW;
      if (m_wim[tgt]) e_unf = 1; else ncwp = tgt;
    end
    if (we) mwrite(wa, wd);             // R11: pre-move window
    if (mwe) m_wim = mw;                // R12: old mask used above
    m_cwp = ncwp;
    ctag = (sv && rs) ? "R9" : sv ? "R4/R7" : rs ? "R4/R8" : "R4";
    @(posedge clk);
    @(negedge clk);
    if (va) chk({ttag, rtag(ra), " port A"}, rd_data_a, ea);
    if (vb) chk({ttag, rtag(rb), " port B"}, rd_data_b, eb);
    chk({ttag, ctag, " cwp"}, DW'(cwp), DW'(m_cwp));
    chk({ttag, "R7 trap_ovf"}, DW'(trap_ovf), DW'(e_ovf));
    chk({ttag, "R8 trap_unf"}, DW'(trap_unf), DW'(e_unf));
    save = 0; restore = 0; wr_en = 0; mask_we = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 8; k++) begin
      v_glob[k] = 0;
      for (int w = 0; w < NW; w++) begin v_out[w][k] = 0; v_loc[w][k] = 0; end
    end
    m_wim = '0; m_cwp = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 cwp", DW'(cwp), '0);
    chk("R1 traps", DW'({trap_ovf, trap_unf}), '0);

    // R3: write to r0 discarded, reads zero
    step(0,0,1, 0, 32'hDEAD_BEEF, 0, 0, 0, '0, "R3 ");
    step(0,0,0, 0, '0, 0, 0, 0, '0, "R3 ");
    // R2 / R10: same-cycle read sees old, next read sees new
    step(0,0,1, 3, 32'h1111_0003, 0, 0, 0, '0, "R2 ");
    step(0,0,1, 3, 32'h2222_0003, 3, 3, 0, '0, "R10 ");
    step(0,0,0, 0, '0, 3, 0, 0, '0, "R10 ");
    // R5 / R4 wrap: outs of w0 become ins of w3 after save
    step(0,0,1, 10, 32'hA0A0_000A, 0, 0, 0, '0, "R5 ");
    step(0,0,1, 20, 32'hC0C0_0014, 0, 0, 0, '0, "R6 ");
    step(1,0,0, 0, '0, 0, 0, 0, '0, "R4 ");
    step(0,0,1, 20, 32'hC1C1_0014, 26, 3, 0, '0, "R5 ");
    // R11: write during restore lands in the pre-move window (w3 local)
    step(0,1,1, 17, 32'hB3B3_0011, 0, 0, 0, '0, "R11 ");
    step(0,0,0, 0, '0, 20, 17, 0, '0, "R6 ");
    step(1,0,0, 0, '0, 0, 0, 0, '0, "R11 ");
    step(0,0,0, 0, '0, 17, 20, 0, '0, "R11 ");
    // R12: mask loaded with a save in the same cycle checks old mask
    step(1,0,0, 0, '0, 0, 0, 1, 4'b0010, "R12 ");   // 3 -> 2, mask now w1
    step(1,0,0, 0, '0, 0, 0, 0, '0, "R7 ");         // 2 -> 1 refused
    step(1,0,0, 0, '0, 0, 0, 0, '0, "R7 ");         // refused again
    step(0,1,0, 0, '0, 0, 0, 1, 4'b1000, "R12 ");   // 2 -> 3 moves, mask now w3
    step(1,0,0, 0, '0, 0, 0, 0, '0, "R4 ");         // 3 -> 2
    step(0,1,0, 0, '0, 0, 0, 0, '0, "R8 ");         // 2 -> 3 refused
    // R9: both strobes together
    step(1,1,0, 0, '0, 0, 0, 0, '0, "R9 ");
    step(0,0,0, 0, '0, 0, 0, 1, '0, "R12 ");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      bit sv = (r < 22) || (r >= 97);
      bit rs = (r >= 22 && r < 44) || (r >= 97);
      bit mwe = ($urandom_range(0, 99) < 4);
      logic [NW-1:0] mw = ($urandom_range(0, 3) == 0) ? '0
                          : NW'($urandom & $urandom & $urandom);
      step(sv, rs, $urandom_range(0, 99) < 60, $urandom_range(0, 31), $urandom,
           $urandom_range(0, 31), $urandom_range(0, 31), mwe, mw, "RND ");
    end
    finish_run();
  end
endmodule